// File: doc/BRIEF.md
# Event State Page Handler

This block serves 8-byte load and store accesses to a memory-mapped window in which every event queue descriptor owns two adjacent pages. The even page of the pair operates on the descriptor's notification state and the odd page on its escalation state. Each state is a two-bit pair, P (pending) and Q (queued), held in a small register array inside the block, with two independent pairs per descriptor.

The offset inside a page selects the operation. Loads can acknowledge (EOI), read the pair, or force the pair to a fixed value. Stores can trigger, acknowledge, or inject a notification. The block reads the addressed pair, applies the operation, writes the pair back when its value changes, and answers a load with a data word one cycle later. When a store leads to a notification it raises a one-cycle notify pulse tagged with the descriptor index and the page kind. The routing that acts on that pulse sits outside this block.

Which descriptors exist is fixed by a parameter mask. An access to a missing descriptor, an access of the wrong size, or an unknown offset reads as all ones and changes no state.

Top module: `esb_page_handler`

## Requirements
- R1: The descriptor index is req_addr >> (PAGE_SHIFT+1). Bit PAGE_SHIFT of the address selects the pair: 0 selects the notification pair and 1 selects the escalation pair. PAGE_SHIFT must be 12 or 16, and any other value stops elaboration. An index of NUM_DESC or above, or an index whose DESC_VALID bit is 0, is an invalid descriptor.
- R2: Only req_size == 8 is a valid access. Any other size is handled like an unknown offset.
- R3: A store at page offset 0x000-0x3FF is a trigger. The state moves 00->10 and raises notify. It moves 10->11, 11->11 and 01->11 with no notify. In a state value, P is bit 1 and Q is bit 0.
- R4: EOI is a load at offset 0x000-0x7FF or a store at offset 0x400-0x7FF. It clears P. If the old Q was 1 the state becomes 10, otherwise 00. A load EOI returns the old Q in data bit 0, with all other bits 0. A store EOI raises notify when the old Q was 1.
- R5: A load at offset 0x800-0xBFF returns the pair zero-extended as {P,Q} and leaves it unchanged.
- R6: A load at offset 0xC00-0xFFF sets the pair to offset bits [9:8] (P = bit 9, Q = bit 8) and returns the old pair zero-extended.
- R7: A store at offset 0x800-0xBFF on a notification page raises notify and leaves the pair unchanged. On an escalation page it is ignored: no notify and no state change.
- R8: A load at an unknown offset or to an invalid descriptor returns all ones. A store at an unknown offset (0xC00-0xFFF) or to an invalid descriptor changes nothing and raises no notify.
- R9: rsp_valid is high exactly one cycle after each accepted load and never after a store. notify pulses one cycle after a notifying store, with notify_idx and notify_esc naming the pair. Loads never raise notify.
- R10: A pair is written only when its new value differs from its old one. Without such a write, every pair holds its value.
- R11: Reset clears every pair to 00 and holds rsp_valid and notify low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address within the page window |
| req_size | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Load result |
| notify | output | 1 | One-cycle notification pulse |
| notify_idx | output | IDX_W | Descriptor index of the notification |
| notify_esc | output | 1 | 1 when the notification comes from the escalation pair |

## Verification
The checker enforces on every cycle the response timing of loads and stores, the absence of notify after loads, the all-ones answer to rejected loads, and the rule that state changes only through a write enable that fires on a real change. Get loads are also checked to leave all state alone. The transition tables for trigger, EOI and set, the page-parity split between the two pairs, the inject rejection on escalation pages and the descriptor mask can only be shown by the bench. The bench does this by comparing every response and pulse against its own model of all pairs over directed and random access sequences.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_TRIG,
    OP_INJECT
  } esb_op_e;

  // Bit 1 = P (pending), bit 0 = Q (queued)
  typedef logic [1:0] pq_t;

  function automatic pq_t pq_after_trigger(pq_t s);
    return (s == 2'b00) ? 2'b10 : 2'b11;
  endfunction

  function automatic logic trigger_fires(pq_t s);
    return s == 2'b00;
  endfunction

  function automatic pq_t pq_after_eoi(pq_t s);
    return s[0] ? 2'b10 : 2'b00;
  endfunction

  function automatic esb_op_e decode_offset(logic is_store, logic [11:0] off);
    esb_op_e op;
    if (!is_store) begin
      if (!off[11])                op = OP_EOI;
      else if (off[11:10] == 2'b10) op = OP_GET;
      else                          op = OP_SET;
    end else begin
      case (off[11:10])
        2'b00:   op = OP_TRIG;
        2'b01:   op = OP_EOI;
        2'b10:   op = OP_INJECT;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 8,
  parameter logic [NUM_DESC-1:0] DESC_VALID = '1,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_store,
  input  logic [3:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              esc,
  output esb_op_e           op,
  output logic [1:0]        set_val,
  output logic              ok
);
  localparam logic [ADDR_W-1:0] NUM_DESC_A = ADDR_W'(NUM_DESC);

  logic [ADDR_W-1:0] idx_full;
  logic [11:0]       off;
  logic              desc_ok;

  assign idx_full = addr >> (PAGE_SHIFT + 1);
  assign idx      = idx_full[IDX_W-1:0];
  assign esc      = addr[PAGE_SHIFT];
  assign off      = addr[11:0];
  assign set_val  = off[9:8];
  assign op       = decode_offset(is_store, off);
  assign desc_ok  = (idx_full < NUM_DESC_A) && DESC_VALID[idx];
  assign ok       = desc_ok && (size == 4'd8) && (op != OP_NONE) &&
                    !(op == OP_INJECT && esc);
endmodule

// File: rtl/esb_pq_alu.sv
module esb_pq_alu
  import esb_pkg::*;
(
  input  esb_op_e     op,
  input  pq_t         old_pq,
  input  logic [1:0]  set_val,
  output pq_t         new_pq,
  output logic        fire,
  output logic [63:0] rdata
);
  always_comb begin
    new_pq = old_pq;
    fire   = 1'b0;
    rdata  = 64'd0;
    case (op)
      OP_EOI: begin
        new_pq = pq_after_eoi(old_pq);
        fire   = old_pq[0];
        rdata  = {63'd0, old_pq[0]};
      end
      OP_GET:  rdata = {62'd0, old_pq};
      OP_SET: begin
        new_pq = set_val;
        rdata  = {62'd0, old_pq};
      end
      OP_TRIG: begin
        new_pq = pq_after_trigger(old_pq);
        fire   = trigger_fires(old_pq);
      end
      OP_INJECT: fire = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/esb_state_array.sv
module esb_state_array
  import esb_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  esc,
  input  logic                  wr_en,
  input  pq_t                   wr_pq,
  output pq_t                   rd_pq,
  output logic [NUM_DESC*4-1:0] state_flat
);
  pq_t pq_q [NUM_DESC][2];

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    for (genvar e = 0; e < 2; e++) begin : g_pair
      always_ff @(posedge clk) begin
        if (!rst_n)
          pq_q[d][e] <= 2'b00;
        else if (wr_en && (idx == IDX_W'(d)) && (esc == e[0]))
          pq_q[d][e] <= wr_pq;
      end
      assign state_flat[d*4 + e*2 +: 2] = pq_q[d][e];
    end
  end

  assign rd_pq = pq_q[idx][esc];
endmodule

// File: rtl/esb_page_handler.sv
module esb_page_handler
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 8,
  parameter logic [NUM_DESC-1:0] DESC_VALID = 8'hBF,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              notify,
  output logic [IDX_W-1:0]  notify_idx,
  output logic              notify_esc
);
  if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
    $error("esb_page_handler: PAGE_SHIFT must be 12 or 16");
  end

  logic [IDX_W-1:0]      acc_idx;
  logic                  acc_esc;
  esb_op_e               op;
  logic [1:0]            set_val;
  logic                  acc_ok;
  pq_t                   old_pq;
  pq_t                   new_pq;
  logic                  alu_fire;
  logic [63:0]           alu_rdata;
  logic                  wr_en;
  logic                  fire_now;
  logic [NUM_DESC*4-1:0] state_flat;

  esb_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_DESC(NUM_DESC), .DESC_VALID(DESC_VALID)
  ) u_dec (
    .addr(req_addr), .is_store(req_write), .size(req_size),
    .idx(acc_idx), .esc(acc_esc), .op(op), .set_val(set_val), .ok(acc_ok)
  );

  esb_state_array #(.NUM_DESC(NUM_DESC)) u_arr (
    .clk(clk), .rst_n(rst_n), .idx(acc_idx), .esc(acc_esc),
    .wr_en(wr_en), .wr_pq(new_pq), .rd_pq(old_pq), .state_flat(state_flat)
  );

  esb_pq_alu u_alu (
    .op(op), .old_pq(old_pq), .set_val(set_val),
    .new_pq(new_pq), .fire(alu_fire), .rdata(alu_rdata)
  );

  assign wr_en    = req_valid && acc_ok && (new_pq != old_pq);
  assign fire_now = req_valid && req_write && acc_ok && alu_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      notify     <= 1'b0;
      notify_idx <= '0;
      notify_esc <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_data <= acc_ok ? alu_rdata : '1;
      notify <= fire_now;
      if (fire_now) begin
        notify_idx <= acc_idx;
        notify_esc <= acc_esc;
      end
    end
  end
endmodule

// File: rtl/esb_page_handler_chk.sv
module esb_page_handler_chk
  import esb_pkg::*;
#(
  parameter int NUM_DESC = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic                  acc_ok,
  input esb_op_e               op,
  input logic                  wr_en,
  input logic [NUM_DESC*4-1:0] state_flat,
  input logic                  rsp_valid,
  input logic [63:0]           rsp_data,
  input logic                  notify
);
  a_r9_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_no_answer_else: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r9_load_never_notifies: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !notify);

  a_r8_rejected_load_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !acc_ok) |=> (rsp_data == '1));

  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_flat));

  a_r10_write_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state_flat != $past(state_flat)));

  a_r5_get_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_ok && op == OP_GET) |=> $stable(state_flat));
endmodule

bind esb_page_handler esb_page_handler_chk #(.NUM_DESC(NUM_DESC)) u_chk (.*);

// File: tb/tb_esb_page_handler.sv
module tb_esb_page_handler;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        notify;
  logic [2:0]  notify_idx;
  logic        notify_esc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] model [NDESC][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_page_handler dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .notify(notify), .notify_idx(notify_idx),
    .notify_esc(notify_esc)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Descriptor 6 is absent from the mask, 8 and 9 are past the end (R1)
  function automatic bit desc_present(int idx);
    return idx < NDESC && idx != 6;
  endfunction

  task automatic access(input bit wr, input int idx, input bit esc,
                        input logic [11:0] off, input logic [3:0] size);
    logic [1:0]  old = desc_present(idx) ? model[idx][esc] : 2'b00;
    logic [1:0]  nxt;
    logic [63:0] exp_d = '1;
    bit          exp_n = 0;
    bit          good  = 1;
    int          win   = int'(off[11:8]);
    string       req;
    nxt = old;
    if (!wr) begin
      if (win < 8)       begin nxt = old[0] ? 2'b10 : 2'b00; exp_d = 64'(old[0]); req = "R4"; end
      else if (win < 12) begin exp_d = 64'(old); req = "R5"; end
      else               begin nxt = 2'(win); exp_d = 64'(old); req = "R6"; end
    end else begin
      if (win < 4)       begin nxt = (old == 2'b00) ? 2'b10 : 2'b11; exp_n = (old == 2'b00); req = "R3"; end
      else if (win < 8)  begin nxt = old[0] ? 2'b10 : 2'b00; exp_n = old[0]; req = "R4"; end
      else if (win < 12) begin exp_n = 1; req = "R7"; if (esc) good = 0; end
      else               begin good = 0; req = "R8"; end
    end
    if (!desc_present(idx)) begin good = 0; req = "R1"; end
    if (size != 4'd8)       begin good = 0; req = "R2"; end
    if (!good) begin nxt = old; exp_d = '1; exp_n = 0; end

    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 20'((idx << 13) | (int'(esc) << 12) | int'(off));
    req_size  = size;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (!wr) begin
      check(rsp_valid == 1'b1, "R9", "load response valid", 64'(rsp_valid), 64'd1);
      check(rsp_data == exp_d, req, "load data", rsp_data, exp_d);
      check(notify == 1'b0, "R9", "no notify on load", 64'(notify), 64'd0);
    end else begin
      check(rsp_valid == 1'b0, "R9", "no response on store", 64'(rsp_valid), 64'd0);
      check(notify == exp_n, req, "notify", 64'(notify), 64'(exp_n));
      if (exp_n) begin
        check(notify_idx == 3'(idx), "R9", "notify index", 64'(notify_idx), 64'(idx));
        check(notify_esc == esc, "R9", "notify page", 64'(notify_esc), 64'(esc));
      end
    end
    if (desc_present(idx)) model[idx][esc] = nxt;
  endtask

  // Window offsets: EOI load 0x000, get 0x800, set 0xC00..0xF00;
  // trigger store 0x000, EOI store 0x400, inject 0x800, unknown 0xC00
  task automatic get_expect(input int idx, input bit esc, input logic [1:0] v,
                            input string req);
    access(0, idx, esc, 12'h800, 4'd8);
    check(rsp_data == 64'(v), req, "pair read back", rsp_data, 64'(v));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int d = 0; d < NDESC; d++) begin model[d][0] = 2'b00; model[d][1] = 2'b00; end
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid == 1'b0 && notify == 1'b0, "R11", "outputs in reset",
          64'({rsp_valid, notify}), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(rsp_valid == 1'b0 && notify == 1'b0, "R11", "idle after reset",
          64'({rsp_valid, notify}), 64'd0);
    get_expect(0, 0, 2'b00, "R11");
    get_expect(7, 1, 2'b00, "R11");

    // R3 trigger sequence on descriptor 0 notification pair
    access(1, 0, 0, 12'h010, 4'd8);
    access(1, 0, 0, 12'h3F8, 4'd8);
    access(1, 0, 0, 12'h000, 4'd8);
    get_expect(0, 0, 2'b11, "R10");
    // R1 escalation pair untouched by notification page
    get_expect(0, 1, 2'b00, "R1");
    // R4 load EOI returns old Q=1, state goes to 10
    access(0, 0, 0, 12'h000, 4'd8);
    get_expect(0, 0, 2'b10, "R4");
    // R4 store EOI with Q=0 -> 00, no notify
    access(1, 0, 0, 12'h400, 4'd8);
    get_expect(0, 0, 2'b00, "R4");
    // R6 set to 01, then trigger 01 -> 11 silently
    access(0, 2, 1, 12'hD00, 4'd8);
    access(1, 2, 1, 12'h000, 4'd8);
    get_expect(2, 1, 2'b11, "R3");
    // R4 store EOI with Q=1 notifies on the escalation page
    access(1, 2, 1, 12'h7F8, 4'd8);
    get_expect(2, 1, 2'b10, "R4");
    // R7 inject on notification page notifies, escalation page ignored
    access(1, 3, 0, 12'h800, 4'd8);
    access(0, 3, 1, 12'hE00, 4'd8);
    access(1, 3, 1, 12'h808, 4'd8);
    get_expect(3, 1, 2'b10, "R7");
    // R8 unknown store offset, invalid descriptors, R2 bad size
    access(1, 4, 0, 12'hC00, 4'd8);
    get_expect(4, 0, 2'b00, "R8");
    access(0, 6, 0, 12'h800, 4'd8);
    access(1, 6, 0, 12'h000, 4'd8);
    access(0, 8, 0, 12'h800, 4'd8);
    access(1, 9, 1, 12'h000, 4'd8);
    access(0, 5, 0, 12'h800, 4'd4);
    access(1, 5, 0, 12'h000, 4'd2);
    get_expect(5, 0, 2'b00, "R2");

    // Random mix over all windows, both pages, some invalid targets
    for (int i = 0; i < 4000; i++) begin
      int   idx  = int'($urandom_range(0, 9));
      bit   esc  = 1'($urandom_range(0, 1));
      bit   wr   = 1'($urandom_range(0, 1));
      logic [11:0] off = 12'($urandom_range(0, 4095)) & 12'hFF8;
      logic [3:0]  sz  = ($urandom_range(0, 15) == 0) ? 4'd4 : 4'd8;
      access(wr, idx, esc, off, sz);
      if ($urandom_range(0, 7) == 0) begin
        @(posedge clk);
        #1;
        check(rsp_valid == 1'b0 && notify == 1'b0, "R9", "idle cycle quiet",
              64'({rsp_valid, notify}), 64'd0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule